// File: doc/BRIEF.md
# NAND Page Byte-Order Remapper

This block turns the byte order a NAND controller uses inside a page into addresses of a flat raw buffer. The controller walks each chunk of a page as a data section, then a free spare section, then an ECC section. The raw buffer keeps every data byte of the page first, every free spare byte after that, and every ECC byte at the end. For each byte the controller walks, the block emits the raw-buffer address of that byte and a tag that names its section. A DMA or buffer engine can use these addresses to scatter or gather one page between the two layouts.

A single start pulse captures the configuration. It gives the data, spare and ECC lengths shared by the regular chunks, the number of regular chunks, and a separate set of three lengths for the final chunk. The block then streams one address per accepted beat on a valid/ready output. When the consumer holds ready low, the current beat stays on the port unchanged. A section of length zero is passed over without spending a cycle. A one-cycle done pulse follows the final beat.

Top module: `nand_layout_remap`

## Requirements
- R1: Beats come out chunk by chunk, with chunk index rising. The regular chunks 0 to N-1 all use the regular lengths, and chunk N (the final chunk) uses its own three lengths. Inside a chunk the order is every data byte, then every spare byte, then every ECC byte, with the offset in each section rising from 0.
- R2: A data beat at offset o of chunk c has address c*Ld + o, where Ld is the regular data length.
- R3: A spare beat at offset o of chunk c has address TD + c*Ls + o. TD is the sum of all data lengths, N*Ld plus the final data length, and Ls is the regular spare length.
- R4: An ECC beat at offset o of chunk c has address TD + TS + c*Le + o. TS is the sum of all spare lengths, and Le is the regular ECC length.
- R5: The section tag m_sect_o is 2'd0 for data, 2'd1 for spare and 2'd2 for ECC. It never reads 2'd3 while m_valid_o is high.
- R6: A section of zero length produces no beat and no idle cycle. When the regular lengths are all zero, the regular chunks produce nothing and the final chunk follows at once.
- R7: A beat transfers on a clock edge where m_valid_o and m_ready_i are both high. With ready held high there is one beat per cycle. While ready is low, valid, address and tag hold steady.
- R8: done_o is high for exactly one cycle, the cycle after the final beat transfers, and m_valid_o is low in that cycle.
- R9: With zero regular chunks and a final chunk whose three lengths are all zero, done_o rises in the cycle after the start pulse and no beat appears.
- R10: start_i is taken only while the block is idle, and the configuration is captured on that edge. A start during a run, and any change on the configuration inputs during a run, leave the stream unchanged.
- R11: After reset, m_valid_o and done_o are low.
- R12: Data lengths up to MAX_DATA (2048) bytes per chunk are supported, in both the regular chunks and the final chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; captures the configuration when idle |
| cfg_full_chunks_i | input | CNT_W | Number of regular chunks N |
| cfg_data_len_i | input | LEN_W | Regular chunk data length |
| cfg_spare_len_i | input | LEN_W | Regular chunk spare length |
| cfg_ecc_len_i | input | LEN_W | Regular chunk ECC length |
| cfg_last_data_len_i | input | LEN_W | Final chunk data length |
| cfg_last_spare_len_i | input | LEN_W | Final chunk spare length |
| cfg_last_ecc_len_i | input | LEN_W | Final chunk ECC length |
| m_valid_o | output | 1 | Beat available |
| m_ready_i | input | 1 | Consumer accepts the beat |
| m_addr_o | output | ADDR_W | Raw-buffer address of the beat |
| m_sect_o | output | 2 | Section tag (0 data, 1 spare, 2 ECC) |
| done_o | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench runs several configurations against a queue-based model, comparing on every cycle:
- Final lengths that differ from the regular ones. A design that reused the regular lengths for the final chunk would send spare and ECC beats to the wrong bases.
- Zero-length sections. A design that failed to skip one would put out a beat with a stale address, or an idle bubble that the per-cycle compare catches.
- All-zero regular chunks, and an all-zero final chunk. A wrong skip here would hang the block or emit beats that should not exist.
- An empty page. This must give a done pulse and no beat.
- Random and sparse ready, together with a start pulse and scrambled configuration inputs driven during a run. These expose beats that move or restart under stall.

// File: rtl/nlr_pkg.sv
package nlr_pkg;
  localparam int NUM_SECT = 3;

  typedef enum logic [1:0] {
    SEC_DATA  = 2'd0,
    SEC_SPARE = 2'd1,
    SEC_ECC   = 2'd2
  } sect_e;
endpackage

// File: rtl/nlr_seek.sv
// Finds the first non-empty section at or after (chunk_i, from_i) in walk order.
module nlr_seek #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0]                         chunk_i,
  input  logic [1:0]                               from_i,
  input  logic [nlr_pkg::NUM_SECT-1:0][LEN_W-1:0]  reg_len_i,
  input  logic [nlr_pkg::NUM_SECT-1:0][LEN_W-1:0]  last_len_i,
  input  logic [CNT_W-1:0]                         full_i,
  output logic                                     found_o,
  output logic [CNT_W-1:0]                         chunk_o,
  output logic [1:0]                               sect_o
);
  localparam int NS = nlr_pkg::NUM_SECT;
  localparam logic [CNT_W:0] ONE_X = 1;

  logic                       in_last;
  logic [NS-1:0][LEN_W-1:0]   here_len;
  logic [NS-1:0]              here_nz, reg_nz, last_nz;
  logic [CNT_W:0]             next_chunk;

  assign in_last    = (chunk_i == full_i);
  assign here_len   = in_last ? last_len_i : reg_len_i;
  assign next_chunk = {1'b0, chunk_i} + ONE_X;

  for (genvar g = 0; g < NS; g++) begin : g_nz
    assign here_nz[g] = (here_len[g]   != '0) && (2'(g) >= from_i);
    assign reg_nz[g]  = (reg_len_i[g]  != '0);
    assign last_nz[g] = (last_len_i[g] != '0);
  end

  always_comb begin
    found_o = 1'b0;
    chunk_o = chunk_i;
    sect_o  = 2'd0;
    for (int i = 0; i < NS; i++) begin
      if (!found_o && here_nz[i]) begin
        found_o = 1'b1;
        sect_o  = 2'(i);
      end
    end
    if (!found_o && !in_last) begin
      if ((next_chunk < {1'b0, full_i}) && (|reg_nz)) begin
        chunk_o = next_chunk[CNT_W-1:0];
        for (int i = 0; i < NS; i++) begin
          if (!found_o && reg_nz[i]) begin
            found_o = 1'b1;
            sect_o  = 2'(i);
          end
        end
      end else begin
        chunk_o = full_i;
        for (int i = 0; i < NS; i++) begin
          if (!found_o && last_nz[i]) begin
            found_o = 1'b1;
            sect_o  = 2'(i);
          end
        end
      end
    end
  end
endmodule

// File: rtl/nlr_cfg_regs.sv
// Captures the layout on a start and derives section base addresses.
module nlr_cfg_regs #(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 18
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     take_i,
  input  logic [nlr_pkg::NUM_SECT-1:0][LEN_W-1:0]  reg_len_i,
  input  logic [nlr_pkg::NUM_SECT-1:0][LEN_W-1:0]  last_len_i,
  input  logic [CNT_W-1:0]                         full_i,
  output logic [nlr_pkg::NUM_SECT-1:0][LEN_W-1:0]  reg_len_o,
  output logic [nlr_pkg::NUM_SECT-1:0][LEN_W-1:0]  last_len_o,
  output logic [CNT_W-1:0]                         full_o,
  output logic [ADDR_W-1:0]                        base_spare_o,
  output logic [ADDR_W-1:0]                        base_ecc_o,
  output logic [ADDR_W-1:0]                        total_o
);
  localparam int NS = nlr_pkg::NUM_SECT;

  logic [NS-1:0][ADDR_W-1:0] sect_sum;

  for (genvar g = 0; g < NS; g++) begin : g_sum
    assign sect_sum[g] = ADDR_W'(full_i) * ADDR_W'(reg_len_i[g]) + ADDR_W'(last_len_i[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_len_o    <= '0;
      last_len_o   <= '0;
      full_o       <= '0;
      base_spare_o <= '0;
      base_ecc_o   <= '0;
      total_o      <= '0;
    end else if (take_i) begin
      reg_len_o    <= reg_len_i;
      last_len_o   <= last_len_i;
      full_o       <= full_i;
      base_spare_o <= sect_sum[0];
      base_ecc_o   <= sect_sum[0] + sect_sum[1];
      total_o      <= sect_sum[0] + sect_sum[1] + sect_sum[2];
    end
  end
endmodule

// File: rtl/nlr_walker.sv
// Position state: chunk, section and offset in controller order.
module nlr_walker #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     take_i,
  input  logic                                     ready_i,
  input  logic [nlr_pkg::NUM_SECT-1:0][LEN_W-1:0]  reg_len_i,
  input  logic [nlr_pkg::NUM_SECT-1:0][LEN_W-1:0]  last_len_i,
  input  logic [CNT_W-1:0]                         full_i,
  output logic                                     valid_o,
  output logic [CNT_W-1:0]                         chunk_o,
  output logic [1:0]                               sect_o,
  output logic [LEN_W-1:0]                         off_o,
  output logic                                     done_o
);
  localparam logic [LEN_W-1:0] ONE_L = 1;

  logic             busy_q, done_q;
  logic [CNT_W-1:0] chunk_q;
  logic [1:0]       sect_q;
  logic [LEN_W-1:0] off_q;
  logic [LEN_W-1:0] cur_len;
  logic             last_byte;

  logic             first_found, next_found;
  logic [CNT_W-1:0] first_chunk, next_chunk;
  logic [1:0]       first_sect, next_sect;

  assign cur_len   = (chunk_q == full_i) ? last_len_i[sect_q] : reg_len_i[sect_q];
  assign last_byte = (off_q == cur_len - ONE_L);

  nlr_seek #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_seek_first (
    .chunk_i(CNT_W'(0)), .from_i(2'd0),
    .reg_len_i(reg_len_i), .last_len_i(last_len_i), .full_i(full_i),
    .found_o(first_found), .chunk_o(first_chunk), .sect_o(first_sect)
  );

  nlr_seek #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_seek_next (
    .chunk_i(chunk_q), .from_i(sect_q + 2'd1),
    .reg_len_i(reg_len_i), .last_len_i(last_len_i), .full_i(full_i),
    .found_o(next_found), .chunk_o(next_chunk), .sect_o(next_sect)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      chunk_q <= '0;
      sect_q  <= 2'd0;
      off_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (take_i) begin
        if (first_found) begin
          busy_q  <= 1'b1;
          chunk_q <= first_chunk;
          sect_q  <= first_sect;
          off_q   <= '0;
        end else begin
          done_q <= 1'b1;
        end
      end else if (busy_q && ready_i) begin
        if (!last_byte) begin
          off_q <= off_q + ONE_L;
        end else if (next_found) begin
          chunk_q <= next_chunk;
          sect_q  <= next_sect;
          off_q   <= '0;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign valid_o = busy_q;
  assign chunk_o = chunk_q;
  assign sect_o  = sect_q;
  assign off_o   = off_q;
  assign done_o  = done_q;

  // R6
  off_in_section_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (off_q < cur_len));

  // R5
  tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (sect_q != 2'd3));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ready_i) |=> (busy_q && $stable(chunk_q) && $stable(sect_q) && $stable(off_q)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R1
  walk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ready_i) |=> (!busy_q || ($past(chunk_q) < chunk_q) ||
      (($past(chunk_q) == chunk_q) && ($past(sect_q) <= sect_q))));
endmodule

// File: rtl/nlr_addr_gen.sv
// Raw-buffer address from the current position.
module nlr_addr_gen #(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 18
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     valid_i,
  input  logic [CNT_W-1:0]                         chunk_i,
  input  logic [1:0]                               sect_i,
  input  logic [LEN_W-1:0]                         off_i,
  input  logic [nlr_pkg::NUM_SECT-1:0][LEN_W-1:0]  reg_len_i,
  input  logic [ADDR_W-1:0]                        base_spare_i,
  input  logic [ADDR_W-1:0]                        base_ecc_i,
  input  logic [ADDR_W-1:0]                        total_i,
  output logic [ADDR_W-1:0]                        addr_o
);
  import nlr_pkg::*;

  logic [ADDR_W-1:0] sect_base;
  logic [ADDR_W-1:0] stride;

  always_comb begin
    case (sect_e'(sect_i))
      SEC_SPARE: sect_base = base_spare_i;
      SEC_ECC:   sect_base = base_ecc_i;
      default:   sect_base = '0;
    endcase
  end

  assign stride = ADDR_W'(chunk_i) * ADDR_W'(reg_len_i[sect_i]);
  assign addr_o = sect_base + stride + ADDR_W'(off_i);

  // R4
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> (addr_o < total_i));
endmodule

// File: rtl/nand_layout_remap.sv
module nand_layout_remap #(
  parameter int LEN_W    = 12,
  parameter int CNT_W    = 4,
  parameter int MAX_DATA = 2048,
  parameter int ADDR_W   = CNT_W + LEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cfg_full_chunks_i,
  input  logic [LEN_W-1:0]  cfg_data_len_i,
  input  logic [LEN_W-1:0]  cfg_spare_len_i,
  input  logic [LEN_W-1:0]  cfg_ecc_len_i,
  input  logic [LEN_W-1:0]  cfg_last_data_len_i,
  input  logic [LEN_W-1:0]  cfg_last_spare_len_i,
  input  logic [LEN_W-1:0]  cfg_last_ecc_len_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [1:0]        m_sect_o,
  output logic              done_o
);
  localparam int NS = nlr_pkg::NUM_SECT;

  logic                       take;
  logic                       busy;
  logic [NS-1:0][LEN_W-1:0]   live_reg, live_last;
  logic [NS-1:0][LEN_W-1:0]   held_reg, held_last;
  logic [NS-1:0][LEN_W-1:0]   use_reg, use_last;
  logic [CNT_W-1:0]           held_full, use_full;
  logic [ADDR_W-1:0]          base_spare, base_ecc, total;
  logic [CNT_W-1:0]           pos_chunk;
  logic [1:0]                 pos_sect;
  logic [LEN_W-1:0]           pos_off;

  assign live_reg  = {cfg_ecc_len_i, cfg_spare_len_i, cfg_data_len_i};
  assign live_last = {cfg_last_ecc_len_i, cfg_last_spare_len_i, cfg_last_data_len_i};
  assign take      = start_i && !busy;
  assign use_reg   = take ? live_reg  : held_reg;
  assign use_last  = take ? live_last : held_last;
  assign use_full  = take ? cfg_full_chunks_i : held_full;

  nlr_cfg_regs #(.LEN_W(LEN_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .take_i(take),
    .reg_len_i(live_reg), .last_len_i(live_last), .full_i(cfg_full_chunks_i),
    .reg_len_o(held_reg), .last_len_o(held_last), .full_o(held_full),
    .base_spare_o(base_spare), .base_ecc_o(base_ecc), .total_o(total)
  );

  nlr_walker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .take_i(take), .ready_i(m_ready_i),
    .reg_len_i(use_reg), .last_len_i(use_last), .full_i(use_full),
    .valid_o(busy), .chunk_o(pos_chunk), .sect_o(pos_sect), .off_o(pos_off),
    .done_o(done_o)
  );

  nlr_addr_gen #(.LEN_W(LEN_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .valid_i(busy),
    .chunk_i(pos_chunk), .sect_i(pos_sect), .off_i(pos_off),
    .reg_len_i(held_reg), .base_spare_i(base_spare), .base_ecc_i(base_ecc),
    .total_i(total), .addr_o(m_addr_o)
  );

  assign m_valid_o = busy;
  assign m_sect_o  = pos_sect;

  // R12
  max_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((int'(cfg_data_len_i) <= MAX_DATA) && (int'(cfg_last_data_len_i) <= MAX_DATA)));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !m_ready_i) |=> (busy && $stable(m_addr_o)));
endmodule

// File: tb/nand_layout_remap_test.sv
module nand_layout_remap_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 12;
  localparam int CNT_W = 4;
  localparam int ADDR_W = CNT_W + LEN_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] cfg_full_chunks_i = '0;
  logic [LEN_W-1:0] cfg_data_len_i = '0, cfg_spare_len_i = '0, cfg_ecc_len_i = '0;
  logic [LEN_W-1:0] cfg_last_data_len_i = '0, cfg_last_spare_len_i = '0, cfg_last_ecc_len_i = '0;
  logic m_valid_o, m_ready_i = 1'b0, done_o;
  logic [ADDR_W-1:0] m_addr_o;
  logic [1:0] m_sect_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int q_addr[$];
  int q_sect[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_layout_remap #(.LEN_W(LEN_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cfg_full_chunks_i(cfg_full_chunks_i),
    .cfg_data_len_i(cfg_data_len_i), .cfg_spare_len_i(cfg_spare_len_i),
    .cfg_ecc_len_i(cfg_ecc_len_i), .cfg_last_data_len_i(cfg_last_data_len_i),
    .cfg_last_spare_len_i(cfg_last_spare_len_i), .cfg_last_ecc_len_i(cfg_last_ecc_len_i),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_addr_o(m_addr_o),
    .m_sect_o(m_sect_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit next_ready(input int mode);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0:       return 1'b1;
      1:       return lfsr[0];
      default: return (lfsr[2:0] == 3'd0);
    endcase
  endfunction

  // Reference: expected beat list from R1-R4 formulas.
  task automatic build(input int n, input int rd, input int rs, input int re,
                       input int ld, input int ls, input int le);
    int rl[3], ll[3], base[3];
    rl = '{rd, rs, re};
    ll = '{ld, ls, le};
    q_addr.delete();
    q_sect.delete();
    base[0] = 0;
    base[1] = n*rd + ld;
    base[2] = base[1] + n*rs + ls;
    for (int c = 0; c <= n; c++)
      for (int s = 0; s < 3; s++)
        for (int o = 0; o < ((c < n) ? rl[s] : ll[s]); o++) begin
          q_addr.push_back(base[s] + c*rl[s] + o);
          q_sect.push_back(s);
        end
  endtask

  task automatic run_case(input string name, input int n, input int rd, input int rs,
                          input int re, input int ld, input int ls, input int le,
                          input int mode, input bit poke);
    bit exp_done;
    bit rdy;
    bit exp_v;
    int iter;
    build(n, rd, rs, re, ld, ls, le);
    @(negedge clk);
    start_i = 1'b1;
    m_ready_i = 1'b0;
    cfg_full_chunks_i = CNT_W'(n);
    cfg_data_len_i = LEN_W'(rd); cfg_spare_len_i = LEN_W'(rs); cfg_ecc_len_i = LEN_W'(re);
    cfg_last_data_len_i = LEN_W'(ld); cfg_last_spare_len_i = LEN_W'(ls);
    cfg_last_ecc_len_i = LEN_W'(le);
    exp_done = (q_addr.size() == 0);
    iter = 0;
    @(negedge clk);
    start_i = 1'b0;
    // R10: scramble configuration inputs during the run
    cfg_full_chunks_i = '1; cfg_data_len_i = 12'd37; cfg_spare_len_i = 12'd5;
    cfg_ecc_len_i = 12'd0; cfg_last_data_len_i = 12'd1; cfg_last_spare_len_i = 12'd0;
    cfg_last_ecc_len_i = 12'd9;
    while (1) begin
      exp_v = (q_addr.size() > 0);
      chk(m_valid_o == exp_v, {name, " R7 valid"}, int'(m_valid_o), int'(exp_v));
      if (exp_v && m_valid_o) begin
        chk(int'(m_sect_o) == q_sect[0], {name, " R5 tag"}, int'(m_sect_o), q_sect[0]);
        case (q_sect[0])
          0: chk(int'(m_addr_o) == q_addr[0], {name, " R2 data addr"}, int'(m_addr_o), q_addr[0]);
          1: chk(int'(m_addr_o) == q_addr[0], {name, " R3 spare addr"}, int'(m_addr_o), q_addr[0]);
          default: chk(int'(m_addr_o) == q_addr[0], {name, " R4 ecc addr"}, int'(m_addr_o), q_addr[0]);
        endcase
      end
      chk(done_o == exp_done, {name, " R8 done"}, int'(done_o), int'(exp_done));
      if (exp_done || iter > 20000) break;
      rdy = next_ready(mode);
      m_ready_i = rdy;
      // R10: start while busy must be ignored
      start_i = (poke && (iter % 7 == 3) && exp_v);
      if (exp_v && rdy) begin
        void'(q_addr.pop_front());
        void'(q_sect.pop_front());
        exp_done = (q_addr.size() == 0);
      end
      iter++;
      @(negedge clk);
    end
    start_i = 1'b0;
    m_ready_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, {name, " R8 pulse width"}, int'(done_o), 0);
    chk(m_valid_o == 1'b0, {name, " R8 idle"}, int'(m_valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_valid_o == 1'b0, "R11 valid after reset", int'(m_valid_o), 0);
    chk(done_o == 1'b0, "R11 done after reset", int'(done_o), 0);

    run_case("R1 uniform",      3, 8, 4, 6,  8, 4, 6, 0, 1'b0);
    run_case("R1 last differs", 2, 5, 3, 2,  7, 0, 4, 1, 1'b0);
    run_case("R6 zero sects",   3, 0, 2, 0,  3, 0, 0, 1, 1'b0);
    run_case("R6 no regular",   0, 9, 9, 9,  4, 2, 1, 0, 1'b0);
    run_case("R6 empty regular",4, 0, 0, 0,  2, 1, 1, 1, 1'b0);
    run_case("R9 empty page",   0, 0, 0, 0,  0, 0, 0, 0, 1'b0);
    run_case("R6 empty last",   2, 3, 1, 2,  0, 0, 0, 1, 1'b0);
    run_case("R7 sparse ready", 2, 6, 2, 3,  4, 5, 1, 2, 1'b0);
    run_case("R10 start busy",  3, 4, 2, 3,  2, 2, 2, 1, 1'b1);
    run_case("R12 max data",    1, 2048, 0, 2, 16, 4, 4, 0, 1'b0);
    run_case("R9 empty again",  0, 0, 0, 0,  0, 0, 0, 1, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule